// File: doc/BRIEF.md
# Dual-Edge Multiplexed Video Input Splitter

This block sits at the pixel input of a video encoder. A single 8-bit port carries two independent 4:2:2 component streams, interleaved byte by byte. One stream is valid at the rising clock edge and the other at the falling edge, so each stream runs at the clock rate and the port runs at twice that rate. The block captures both streams and moves the falling-edge stream onto the rising edge. It then decodes each stream on its own and delivers two pixel channels: one for the encoding path and one for the baseband path.

Each stream carries embedded timing reference codes. Each code is the preamble FF 00 00 followed by a status byte. The decoder takes the field bit (bit 6), the vertical-blanking bit (bit 5) and the line-end bit (bit 4) from the status byte. It does so only when the four protection bits match. After a start-of-line code, the decoder walks through the byte order Cb, Y, Cr, Y. On every second luma byte it emits one chroma pair with its two luma samples, together with the index of the first pixel. It checks the line length at the end-of-line code. A swap input exchanges which stream feeds which channel. The swap only takes effect at a line start.

Top module: `vid_dual_split`

## Requirements
- R1: The byte on `vid_in` at each rising edge belongs to stream A, and the byte at the following falling edge belongs to stream B. Both streams reach their decoders on the same cycle, with the same latency.
- R2: A timing code is FF, 00, 00 followed by a status byte. The channel's `field` output follows status bit 6 and its `vblank` output follows bit 5. Both outputs change on the second rising edge after the edge that captured the status byte.
- R3: A status byte is accepted only when bit 7 is 1, bit 3 = V^H, bit 2 = F^H, bit 1 = F^V and bit 0 = F^V^H. A status byte that fails this check leaves `field`, `vblank`, `active` and the routing unchanged.
- R4: `active` goes to 1 after an accepted status byte with bit 4 = 0 (line start). It goes to 0 after an accepted status byte with bit 4 = 1 (line end). While `active` is 0, incoming bytes produce no pairs.
- R5: After a line start, bytes are taken in the order Cb, Y0, Cr, Y1. `pair_vld` pulses for one cycle on the fifth rising edge after the edge that captured Y1.
- R6: `pix_idx` holds the index of the pair's first pixel: 0, 2, 4 and so on. It restarts at 0 on every line start.
- R7: `line_err` pulses for one cycle, two edges after an accepted line-end status byte, when the line was active and the number of emitted pixels is not ACTIVE_PIX (720). A line-end code that arrives while the line is inactive raises no error.
- R8: The four bytes of a timing code never enter pixel data.
- R9: With the routing at 0, stream A drives the `enc_` channel and stream B drives the `base_` channel. With the routing at 1 the two are exchanged. The routing loads `swap_req` only at an accepted line start on the stream that currently feeds the `enc_` channel, and it is visible two edges after that status byte. `swap_active` shows the current routing.
- R10: While `rst_n` is low, every output is 0 and the routing is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the port carries one byte per edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_in | input | 8 | Byte-multiplexed video port |
| swap_req | input | 1 | Requested routing, loaded at a line start |
| enc_cb | output | 8 | Encoding channel, Cb of the pair |
| enc_y0 | output | 8 | Encoding channel, first luma sample |
| enc_cr | output | 8 | Encoding channel, Cr of the pair |
| enc_y1 | output | 8 | Encoding channel, second luma sample |
| enc_pair_vld | output | 1 | Encoding channel pair strobe |
| enc_pix_idx | output | 10 | Encoding channel index of first pixel |
| enc_active | output | 1 | Encoding channel inside active line |
| enc_field | output | 1 | Encoding channel field bit |
| enc_vblank | output | 1 | Encoding channel vertical blanking bit |
| enc_line_err | output | 1 | Encoding channel line length error pulse |
| base_cb | output | 8 | Baseband channel, Cb of the pair |
| base_y0 | output | 8 | Baseband channel, first luma sample |
| base_cr | output | 8 | Baseband channel, Cr of the pair |
| base_y1 | output | 8 | Baseband channel, second luma sample |
| base_pair_vld | output | 1 | Baseband channel pair strobe |
| base_pix_idx | output | 10 | Baseband channel index of first pixel |
| base_active | output | 1 | Baseband channel inside active line |
| base_field | output | 1 | Baseband channel field bit |
| base_vblank | output | 1 | Baseband channel vertical blanking bit |
| base_line_err | output | 1 | Baseband channel line length error pulse |
| swap_active | output | 1 | Current routing of streams to channels |

## Verification
The timing outputs (`field`, `vblank`, `active`), the routing and `line_err` all change two rising edges after the edge that captured the status byte. A pixel pair appears five rising edges after the edge that captured its second luma byte. The bench places every expected event in an eight-slot ring, keyed by the edge number on which the event is due. It compares both channels 3 ns after every rising edge, so each result is checked in exactly its own cycle and a missing or extra pair strobe shows up at once. Stimulus mixes random pixel bytes, random field and blanking bits, random swaps and random short lines with directed cases. The directed cases are bad protection bits, line ends that arrive while no line is active, and a line that is too long.

// File: rtl/vsplit_pkg.sv
package vsplit_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] TRS_LEAD = 8'hFF;
  localparam logic [7:0] TRS_ZERO = 8'h00;

  // One chroma pair with its two co-sited luma samples.
  typedef struct packed {
    logic [7:0] cb;
    logic [7:0] y0;
    logic [7:0] cr;
    logic [7:0] y1;
  } vs_pair_t;

  // Timing flags carried by a status byte.
  typedef struct packed {
    logic field;
    logic vblank;
    logic hend;
  } vs_trs_t;

  function automatic vs_trs_t trs_fields(input logic [7:0] s);
    vs_trs_t t;
    t.field  = s[6];
    t.vblank = s[5];
    t.hend   = s[4];
    return t;
  endfunction

  // Protection check: the low nibble must be the parity set of F, V, H.
  function automatic logic trs_prot_ok(input logic [7:0] s);
    logic f, v, h;
    f = s[6];
    v = s[5];
    h = s[4];
    return s[7] && (s[3] == (v ^ h)) && (s[2] == (f ^ h)) &&
           (s[1] == (f ^ v)) && (s[0] == (f ^ v ^ h));
  endfunction

endpackage

// File: rtl/vsplit_capture.sv
module vsplit_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rise_b,
  output logic [DW-1:0] fall_b
);

  logic [DW-1:0] rise_q, rise_r;
  logic [DW-1:0] fall_q, fall_r;

  // Stream B: the byte present at the falling edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= din;
  end

  // Stream A is sampled at the rising edge and delayed one stage, so that it
  // lines up with stream B after B has been moved onto the rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      rise_r <= '0;
      fall_r <= '0;
    end else begin
      rise_q <= din;
      rise_r <= rise_q;
      fall_r <= fall_q;
    end
  end

  assign rise_b = rise_r;
  assign fall_b = fall_r;

endmodule

// File: rtl/vsplit_trs_decoder.sv
module vsplit_trs_decoder
  import vsplit_pkg::*;
#(
  parameter int ACTIVE_PIX = 720,
  localparam int PW = $clog2(ACTIVE_PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    byte_in,
  output vs_pair_t      pair,
  output logic          pair_vld,
  output logic [PW-1:0] pix_idx,
  output logic          active,
  output logic          field,
  output logic          vblank,
  output logic          line_err,
  output logic          sav_ev
);

  localparam int CW = PW + 1;
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] LINE_LEN = CW'(ACTIVE_PIX);

  // Add two pixels to the count, holding at the top value.
  function automatic logic [CW-1:0] step_pair(input logic [CW-1:0] n);
    if (n >= CNT_MAX - CW'(1)) return CNT_MAX;
    return n + CW'(2);
  endfunction

  function automatic logic length_ok(input logic [CW-1:0] n);
    return n == LINE_LEN;
  endfunction

  logic [7:0]    h1, h2, h3;
  logic [1:0]    kill_cnt;
  logic [1:0]    phase;
  logic [CW-1:0] npix;
  logic [7:0]    cb_q, y0_q, cr_q;
  vs_trs_t       st;

  // Event wires, brought out by name so the assertions can use them.
  logic pre_hit, trs_ok, eav_ev, kill, vid_take;

  assign pre_hit  = (h3 == TRS_LEAD) && (h2 == TRS_ZERO) && (h1 == TRS_ZERO);
  assign trs_ok   = pre_hit && trs_prot_ok(byte_in);
  assign st       = trs_fields(byte_in);
  assign sav_ev   = trs_ok && !st.hend;
  assign eav_ev   = trs_ok && st.hend;
  assign kill     = pre_hit || (kill_cnt != 2'd0);
  assign vid_take = active && !kill;

  // Three bytes of look-behind. Video is consumed from h3, so a preamble is
  // recognised before its first byte would reach the pixel path.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 <= '0;
      h2 <= '0;
      h3 <= '0;
    end else begin
      h1 <= byte_in;
      h2 <= h1;
      h3 <= h2;
    end
  end

  // Mask the remaining preamble bytes and the status byte as they pass h3.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 kill_cnt <= 2'd0;
    else if (pre_hit)           kill_cnt <= 2'd3;
    else if (kill_cnt != 2'd0)  kill_cnt <= kill_cnt - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field    <= 1'b0;
      vblank   <= 1'b0;
      active   <= 1'b0;
      line_err <= 1'b0;
    end else begin
      line_err <= eav_ev && active && !length_ok(npix);
      if (trs_ok) begin
        field  <= st.field;
        vblank <= st.vblank;
        active <= !st.hend;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= 2'd0;
      npix     <= '0;
      cb_q     <= '0;
      y0_q     <= '0;
      cr_q     <= '0;
      pair     <= '0;
      pair_vld <= 1'b0;
      pix_idx  <= '0;
    end else begin
      pair_vld <= 1'b0;
      if (sav_ev) begin
        phase <= 2'd0;
        npix  <= '0;
      end else if (vid_take) begin
        phase <= phase + 2'd1;
        unique case (phase)
          2'd0: cb_q <= h3;
          2'd1: y0_q <= h3;
          2'd2: cr_q <= h3;
          default: begin
            pair.cb  <= cb_q;
            pair.y0  <= y0_q;
            pair.cr  <= cr_q;
            pair.y1  <= h3;
            pair_vld <= 1'b1;
            pix_idx  <= npix[PW-1:0];
            npix     <= step_pair(npix);
          end
        endcase
      end
    end
  end

  assert_bad_status_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_hit && !trs_ok) |=> ($stable(field) && $stable(vblank) && $stable(active)));

  assert_sav_opens_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sav_ev |=> (active && (npix == '0)));

  assert_pair_inside_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld |-> $past(active));

  assert_pair_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld |=> !pair_vld);

  assert_even_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld |-> (pix_idx[0] == 1'b0));

  assert_err_at_line_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |-> ($past(active) && !active));

  assert_no_code_in_pixels_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pre_hit |=> !pair_vld);

endmodule

// File: rtl/vsplit_router.sv
module vsplit_router (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sav_vec,
  input  logic       swap_req,
  output logic       route_q
);

  // The routing changes only at a line start on the stream that currently
  // feeds the encoding channel.
  logic lead_sav;
  assign lead_sav = route_q ? sav_vec[1] : sav_vec[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        route_q <= 1'b0;
    else if (lead_sav) route_q <= swap_req;
  end

  assert_route_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lead_sav |=> $stable(route_q));

  assert_route_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lead_sav |=> (route_q == $past(swap_req)));

endmodule

// File: rtl/vid_dual_split.sv
module vid_dual_split
  import vsplit_pkg::*;
#(
  parameter int ACTIVE_PIX = 720,
  localparam int PW = $clog2(ACTIVE_PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    vid_in,
  input  logic          swap_req,
  output logic [7:0]    enc_cb,
  output logic [7:0]    enc_y0,
  output logic [7:0]    enc_cr,
  output logic [7:0]    enc_y1,
  output logic          enc_pair_vld,
  output logic [PW-1:0] enc_pix_idx,
  output logic          enc_active,
  output logic          enc_field,
  output logic          enc_vblank,
  output logic          enc_line_err,
  output logic [7:0]    base_cb,
  output logic [7:0]    base_y0,
  output logic [7:0]    base_cr,
  output logic [7:0]    base_y1,
  output logic          base_pair_vld,
  output logic [PW-1:0] base_pix_idx,
  output logic          base_active,
  output logic          base_field,
  output logic          base_vblank,
  output logic          base_line_err,
  output logic          swap_active
);

  localparam int NSTR = 2;

  logic [BYTE_W-1:0] stream_b [NSTR];
  vs_pair_t          dec_pair [NSTR];
  logic [PW-1:0]     dec_idx  [NSTR];
  logic              dec_pv   [NSTR];
  logic              dec_act  [NSTR];
  logic              dec_f    [NSTR];
  logic              dec_v    [NSTR];
  logic              dec_err  [NSTR];
  logic              dec_sav  [NSTR];

  vs_pair_t          ch_pair  [NSTR];
  logic [PW-1:0]     ch_idx   [NSTR];
  logic              ch_pv    [NSTR];
  logic              ch_act   [NSTR];
  logic              ch_f     [NSTR];
  logic              ch_v     [NSTR];
  logic              ch_err   [NSTR];

  logic route_q;

  vsplit_capture #(.DW(BYTE_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (vid_in),
    .rise_b (stream_b[0]),
    .fall_b (stream_b[1])
  );

  for (genvar g = 0; g < NSTR; g++) begin : g_dec
    vsplit_trs_decoder #(.ACTIVE_PIX(ACTIVE_PIX)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_in  (stream_b[g]),
      .pair     (dec_pair[g]),
      .pair_vld (dec_pv[g]),
      .pix_idx  (dec_idx[g]),
      .active   (dec_act[g]),
      .field    (dec_f[g]),
      .vblank   (dec_v[g]),
      .line_err (dec_err[g]),
      .sav_ev   (dec_sav[g])
    );
  end

  vsplit_router u_router (
    .clk      (clk),
    .rst_n    (rst_n),
    .sav_vec  ({dec_sav[1], dec_sav[0]}),
    .swap_req (swap_req),
    .route_q  (route_q)
  );

  // Channel 0 is the encoding channel and channel 1 the baseband channel.
  for (genvar c = 0; c < NSTR; c++) begin : g_ch
    localparam int ALT = NSTR - 1 - c;
    assign ch_pair[c] = route_q ? dec_pair[ALT] : dec_pair[c];
    assign ch_idx[c]  = route_q ? dec_idx[ALT]  : dec_idx[c];
    assign ch_pv[c]   = route_q ? dec_pv[ALT]   : dec_pv[c];
    assign ch_act[c]  = route_q ? dec_act[ALT]  : dec_act[c];
    assign ch_f[c]    = route_q ? dec_f[ALT]    : dec_f[c];
    assign ch_v[c]    = route_q ? dec_v[ALT]    : dec_v[c];
    assign ch_err[c]  = route_q ? dec_err[ALT]  : dec_err[c];
  end

  assign enc_cb        = ch_pair[0].cb;
  assign enc_y0        = ch_pair[0].y0;
  assign enc_cr        = ch_pair[0].cr;
  assign enc_y1        = ch_pair[0].y1;
  assign enc_pair_vld  = ch_pv[0];
  assign enc_pix_idx   = ch_idx[0];
  assign enc_active    = ch_act[0];
  assign enc_field     = ch_f[0];
  assign enc_vblank    = ch_v[0];
  assign enc_line_err  = ch_err[0];

  assign base_cb       = ch_pair[1].cb;
  assign base_y0       = ch_pair[1].y0;
  assign base_cr       = ch_pair[1].cr;
  assign base_y1       = ch_pair[1].y1;
  assign base_pair_vld = ch_pv[1];
  assign base_pix_idx  = ch_idx[1];
  assign base_active   = ch_act[1];
  assign base_field    = ch_f[1];
  assign base_vblank   = ch_v[1];
  assign base_line_err = ch_err[1];

  assign swap_active   = route_q;

  assert_channels_distinct_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_pv[0] != dec_pv[1]) |-> (enc_pair_vld != base_pair_vld));

endmodule

// File: tb/vid_dual_split_tb.sv
module vid_dual_split_tb;

  localparam int AP = 720;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic [7:0] vid_in;
  logic       swap_req;
  logic [7:0] enc_cb, enc_y0, enc_cr, enc_y1, base_cb, base_y0, base_cr, base_y1;
  logic [9:0] enc_pix_idx, base_pix_idx;
  logic enc_pair_vld, enc_active, enc_field, enc_vblank, enc_line_err;
  logic base_pair_vld, base_active, base_field, base_vblank, base_line_err;
  logic swap_active;

  vid_dual_split u_dut (
    .clk(clk), .rst_n(rst_n), .vid_in(vid_in), .swap_req(swap_req),
    .enc_cb(enc_cb), .enc_y0(enc_y0), .enc_cr(enc_cr), .enc_y1(enc_y1),
    .enc_pair_vld(enc_pair_vld), .enc_pix_idx(enc_pix_idx), .enc_active(enc_active),
    .enc_field(enc_field), .enc_vblank(enc_vblank), .enc_line_err(enc_line_err),
    .base_cb(base_cb), .base_y0(base_y0), .base_cr(base_cr), .base_y1(base_y1),
    .base_pair_vld(base_pair_vld), .base_pix_idx(base_pix_idx), .base_active(base_active),
    .base_field(base_field), .base_vblank(base_vblank), .base_line_err(base_line_err),
    .swap_active(swap_active)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  // Expected events, one ring slot per rising edge; index 0 = stream A.
  bit         sl_pv [2][8];
  logic [7:0] sl_cb [2][8], sl_y0 [2][8], sl_cr [2][8], sl_y1 [2][8];
  int         sl_ix [2][8];
  bit         sl_st [2][8], sl_f [2][8], sl_v [2][8], sl_a [2][8];
  bit         sl_er [2][8];
  bit         sl_rt [8], sl_rv [8];

  // Expected output state and the bench's stream model.
  bit e_f [2], e_v [2], e_a [2];
  bit e_route;
  bit m_act [2];
  int m_npix [2], m_ph [2];
  logic [7:0] m_cb [2], m_y0 [2], m_cr [2];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] mk_status(input bit f, input bit v, input bit h);
    logic [2:0] t;
    t = {f, v, h};
    return {1'b1, t, v ^ h, f ^ h, f ^ v, ^t};
  endfunction

  function automatic logic [7:0] rnd_pix();
    return 8'(1 + ($urandom % 254));
  endfunction

  task automatic compare();
    int k, s;
    logic [7:0] o_cb [2], o_y0 [2], o_cr [2], o_y1 [2];
    int o_ix [2];
    bit o_pv [2], o_a [2], o_f [2], o_v [2], o_er [2];
    k = cyc % 8;
    for (int q = 0; q < 2; q++) begin
      if (sl_st[q][k]) begin
        e_f[q] = sl_f[q][k]; e_v[q] = sl_v[q][k]; e_a[q] = sl_a[q][k];
        sl_st[q][k] = 0;
      end
    end
    if (sl_rt[k]) begin e_route = sl_rv[k]; sl_rt[k] = 0; end
    o_cb[0] = enc_cb;  o_y0[0] = enc_y0;  o_cr[0] = enc_cr;  o_y1[0] = enc_y1;
    o_cb[1] = base_cb; o_y0[1] = base_y0; o_cr[1] = base_cr; o_y1[1] = base_y1;
    o_ix[0] = int'(enc_pix_idx); o_ix[1] = int'(base_pix_idx);
    o_pv[0] = enc_pair_vld; o_pv[1] = base_pair_vld;
    o_a[0] = enc_active;    o_a[1] = base_active;
    o_f[0] = enc_field;     o_f[1] = base_field;
    o_v[0] = enc_vblank;    o_v[1] = base_vblank;
    o_er[0] = enc_line_err; o_er[1] = base_line_err;
    for (int c = 0; c < 2; c++) begin
      s = e_route ? 1 - c : c;
      chk("R5 pair_vld", int'(o_pv[c]), int'(sl_pv[s][k]));
      if (sl_pv[s][k] && o_pv[c]) begin
        chk("R1 R8 cb", int'(o_cb[c]), int'(sl_cb[s][k]));
        chk("R1 R8 y0", int'(o_y0[c]), int'(sl_y0[s][k]));
        chk("R1 R8 cr", int'(o_cr[c]), int'(sl_cr[s][k]));
        chk("R1 R8 y1", int'(o_y1[c]), int'(sl_y1[s][k]));
        chk("R6 pix_idx", o_ix[c], sl_ix[s][k]);
      end
      chk("R4 active", int'(o_a[c]), int'(e_a[s]));
      chk("R2 field", int'(o_f[c]), int'(e_f[s]));
      chk("R2 vblank", int'(o_v[c]), int'(e_v[s]));
      chk("R7 line_err", int'(o_er[c]), int'(sl_er[s][k]));
    end
    chk("R9 swap_active", int'(swap_active), int'(e_route));
    for (int q = 0; q < 2; q++) begin sl_pv[q][k] = 0; sl_er[q][k] = 0; end
  endtask

  // Drive one stream A byte (rising edge) and one stream B byte (falling edge).
  task automatic put(input logic [7:0] a, input logic [7:0] b);
    vid_in = a;
    @(posedge clk);
    cyc++;
    #3 compare();
    #2 vid_in = b;
    @(negedge clk);
    #5;
  endtask

  task automatic vid(input logic [7:0] a, input logic [7:0] b);
    int k;
    logic [7:0] x;
    put(a, b);
    k = (cyc + 5) % 8;
    for (int s = 0; s < 2; s++) begin
      x = (s == 0) ? a : b;
      if (m_act[s]) begin
        case (m_ph[s])
          0: m_cb[s] = x;
          1: m_y0[s] = x;
          2: m_cr[s] = x;
          default: begin
            sl_pv[s][k] = 1; sl_cb[s][k] = m_cb[s]; sl_y0[s][k] = m_y0[s];
            sl_cr[s][k] = m_cr[s]; sl_y1[s][k] = x; sl_ix[s][k] = m_npix[s] % 1024;
            m_npix[s] += 2;
          end
        endcase
        m_ph[s] = (m_ph[s] + 1) % 4;
      end
    end
  endtask

  // bad: 0 = good code, 1 = wrong parity bit, 2 = bit 7 cleared.
  task automatic send_trs(input bit h, input bit fa, input bit va,
                          input bit fb, input bit vb, input int bad);
    logic [7:0] sa, sb;
    int k;
    put(8'hFF, 8'hFF);
    put(8'h00, 8'h00);
    put(8'h00, 8'h00);
    sa = mk_status(fa, va, h);
    sb = mk_status(fb, vb, h);
    if (bad == 1) begin sa ^= 8'h01; sb ^= 8'h01; end
    if (bad == 2) begin sa &= 8'h7F; sb &= 8'h7F; end
    put(sa, sb);
    if (bad == 0) begin
      k = (cyc + 2) % 8;
      for (int s = 0; s < 2; s++) begin
        sl_st[s][k] = 1;
        sl_f[s][k] = (s == 0) ? fa : fb;
        sl_v[s][k] = (s == 0) ? va : vb;
        sl_a[s][k] = !h;
        if (h) begin
          if (m_act[s] && m_npix[s] != AP) sl_er[s][k] = 1;
          m_act[s] = 0;
        end else begin
          m_act[s] = 1; m_npix[s] = 0; m_ph[s] = 0;
        end
      end
      if (!h) begin sl_rt[k] = 1; sl_rv[k] = swap_req; end
    end
  endtask

  task automatic blank(input int n);
    for (int i = 0; i < n; i++)
      if (i % 2 == 0) vid(8'h80, 8'h80);
      else            vid(8'h10, 8'h10);
  endtask

  task automatic line(input int npix, input bit fa, input bit va,
                      input bit fb, input bit vb);
    send_trs(0, fa, va, fb, vb, 0);
    for (int j = 0; j < npix / 2; j++) begin
      vid(rnd_pix(), rnd_pix());
      vid(rnd_pix(), rnd_pix());
      vid(rnd_pix(), rnd_pix());
      vid(rnd_pix(), rnd_pix());
    end
    send_trs(1, fa, va, fb, vb, 0);
    blank(8 + int'($urandom % 5));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd2741));
    rst_n = 1'b0;
    swap_req = 1'b0;
    vid_in = 8'h00;
    @(negedge clk);
    #5;
    // R10: outputs held at zero during reset while the port toggles.
    put(8'hFF, 8'h00);
    put(8'h00, 8'hFF);
    put(8'h80, 8'h10);
    chk("R10 reset pair strobes", int'(enc_pair_vld | base_pair_vld), 0);
    chk("R10 reset state", int'({enc_active, base_active, enc_field, base_field,
                                 enc_vblank, base_vblank, swap_active}), 0);
    chk("R10 reset data", int'({enc_cb, enc_y1, base_cr, base_y0}), 0);
    rst_n = 1'b1;
    blank(6);

    // R2: streams carry different flags on the same line.
    line(AP, 0, 0, 0, 1);

    // R9: request changes in blanking; routing must wait for the line start.
    swap_req = 1'b1;
    blank(5);
    // R3: codes with broken protection are ignored; R4: bytes outside a line.
    send_trs(0, 1, 1, 1, 1, 1);
    for (int i = 0; i < 20; i++) vid(rnd_pix(), rnd_pix());
    send_trs(1, 1, 1, 1, 1, 2);
    blank(4);
    // R7: a line end while inactive raises no error.
    send_trs(1, 0, 0, 0, 1, 0);
    blank(4);

    line(AP, 1, 0, 1, 0);
    // R7: short and long lines.
    line(AP - 20, 0, 1, 1, 1);
    line(AP + 4, 1, 1, 0, 0);
    swap_req = 1'b0;
    line(AP, 0, 0, 1, 0);

    for (int r = 0; r < 10; r++) begin
      swap_req = 1'($urandom % 2);
      n = (($urandom % 4) == 0) ? AP - 2 * int'(1 + $urandom % 8) : AP;
      line(n, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
    end
    blank(8);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule